// File: doc/BRIEF.md
# DDR2 Bank State Guard

This block sits beside a DDR2 memory controller and watches the command stream it issues, one command per clock. It decodes the four active-low command strobes, keeps an open or idle state and the latched row for each of eight banks, and raises a one-cycle flag when a command is not allowed in the current state. Legal commands update the bank state. Illegal commands are reported and otherwise ignored.

Address bit 10 has two roles. On a precharge it selects between closing one bank and closing every bank. On a read or write it requests an automatic close of that bank once the burst ends. A small per-bank countdown times that close. A global countdown tracks whether a burst is still in flight, because refresh and mode loads must wait for both the banks and the data bus to go quiet. Integration and protocol checkers use the open flags, the all-idle output and the row readback to follow the device.

Top module: `ddr2_bank_guard`

## Requirements
- R1: After reset, every bank is idle, `all_idle` is 1 and `cmd_bad` is 0.
- R2: An ACTIVATE to an idle bank opens it and latches `addr` as its row, which `cur_row` shows while `bank_sel` names that bank. An ACTIVATE to a bank that is already open is illegal.
- R3: A READ or WRITE to an idle bank is illegal. A READ or WRITE to an open bank with no pending automatic close is legal.
- R4: A PRECHARGE with address bit 10 low closes only the bank on `bank_sel`. With bit 10 high it closes all banks and cancels every pending automatic close. A PRECHARGE is always legal.
- R5: A legal READ or WRITE with address bit 10 high keeps the bank open for BL/2 more clock edges and then closes it. `bl8`=1 gives 4 edges and 0 gives 2. A READ or WRITE to that bank before it closes is illegal.
- R6: REFRESH and LOAD MODE are legal only when no bank is open and no burst is in flight. A burst is in flight for the BL/2 clock edges that follow a legal READ or WRITE.
- R7: NOP and DESELECT are always legal and change no bank state.
- R8: The strobes {`sel_n`,`row_n`,`col_n`,`wen_n`} encode LOAD MODE=0000, REFRESH=0001, PRECHARGE=0010, ACTIVATE=0011, WRITE=0100, READ=0101 and NOP=0111. `sel_n`=1 is DESELECT. Code 0110 is reserved and illegal. `cmd_bad` is high for exactly the one cycle after an illegal command.
- R9: An illegal command changes no bank state and no latched row.
- R10: A command is judged against the state before an automatic close that expires on the same edge. That expiry still takes effect together with any legal command to another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Chip select strobe, active low |
| row_n | input | 1 | Row strobe, active low |
| col_n | input | 1 | Column strobe, active low |
| wen_n | input | 1 | Write-enable strobe, active low |
| bank_sel | input | 3 | Bank addressed by the command |
| addr | input | 14 | Row or column address; bit 10 selects all-bank or automatic close |
| bl8 | input | 1 | Burst length of a read or write: 1 for eight, 0 for four |
| bank_open | output | 8 | One bit per bank, 1 while that bank holds an open row |
| cur_row | output | 14 | Latched row of the bank on `bank_sel` |
| cmd_bad | output | 1 | One-cycle pulse after an illegal command |
| all_idle | output | 1 | 1 when no bank is open |

## Verification
An automatic close can expire on the same edge that a new command arrives, either at that same bank or at a different one. The bench places an ACTIVATE to the closing bank exactly on its expiry edge and expects an illegal flag with the bank closed afterwards. It then issues a second ACTIVATE, which must succeed. For an eight-beat write with automatic close, it sends an ACTIVATE to another bank on the expiry edge and expects both effects in the next cycle: the old bank closed and the new bank open.

// File: rtl/ddr2_bank_guard.sv
module ddr2_bank_guard #(
  parameter int NBANK  = 8,
  parameter int ROW_W  = 14,
  parameter int AP_BIT = 10,
  localparam int BA_W  = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             row_n,
  input  logic             col_n,
  input  logic             wen_n,
  input  logic [BA_W-1:0]  bank_sel,
  input  logic [ROW_W-1:0] addr,
  input  logic             bl8,
  output logic [NBANK-1:0] bank_open,
  output logic [ROW_W-1:0] cur_row,
  output logic             cmd_bad,
  output logic             all_idle
);
  localparam int HALF_LONG  = 4;
  localparam int HALF_SHORT = 2;
  localparam int CNT_W      = $clog2(HALF_LONG + 1);

  logic [3:0] code;
  logic is_act, is_rd, is_wr, is_pre, is_ref, is_lm, is_resv, is_rw;
  logic tgt_open, tgt_busy, quiet, bad;
  logic [CNT_W-1:0] half, burst_left;
  logic [NBANK-1:0] busy;
  logic [ROW_W-1:0] rows [NBANK];

  assign code    = {sel_n, row_n, col_n, wen_n};
  assign is_lm   = code == 4'b0000;
  assign is_ref  = code == 4'b0001;
  assign is_pre  = code == 4'b0010;
  assign is_act  = code == 4'b0011;
  assign is_wr   = code == 4'b0100;
  assign is_rd   = code == 4'b0101;
  assign is_resv = code == 4'b0110;
  assign is_rw   = is_rd | is_wr;

  assign half     = bl8 ? CNT_W'(HALF_LONG) : CNT_W'(HALF_SHORT);
  assign tgt_open = bank_open[bank_sel];
  assign tgt_busy = busy[bank_sel];
  assign quiet    = (bank_open == '0) && (burst_left == '0);

  assign bad = (is_act & tgt_open)
             | (is_rw & (~tgt_open | tgt_busy))
             | ((is_ref | is_lm) & ~quiet)
             | is_resv;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic             o_q;
    logic [CNT_W-1:0] c_q;
    logic [ROW_W-1:0] r_q;
    logic             hit;

    assign hit = bank_sel == BA_W'(g);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        o_q <= 1'b0;
        c_q <= '0;
        r_q <= '0;
      end else if (!bad && is_act && hit) begin
        o_q <= 1'b1;
        r_q <= addr;
      end else if (!bad && is_pre && (hit || addr[AP_BIT])) begin
        o_q <= 1'b0;
        c_q <= '0;
      end else if (!bad && is_rw && hit && addr[AP_BIT]) begin
        c_q <= half;
      end else if (c_q == CNT_W'(1)) begin
        o_q <= 1'b0;
        c_q <= '0;
      end else if (c_q != '0) begin
        c_q <= c_q - CNT_W'(1);
      end
    end

    assign bank_open[g] = o_q;
    assign busy[g]      = c_q != '0;
    assign rows[g]      = r_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_left <= '0;
      cmd_bad    <= 1'b0;
    end else begin
      cmd_bad <= bad;
      if (!bad && is_rw)
        burst_left <= half;
      else if (burst_left != '0)
        burst_left <= burst_left - CNT_W'(1);
    end
  end

  assign all_idle = ~|bank_open;
  assign cur_row  = rows[bank_sel];
endmodule

// File: rtl/ddr2_bank_guard_chk.sv
module ddr2_bank_guard_chk #(
  parameter int NBANK = 8,
  localparam int BA_W = $clog2(NBANK)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_n,
  input logic             row_n,
  input logic             col_n,
  input logic             wen_n,
  input logic [BA_W-1:0]  bank_sel,
  input logic             ap,
  input logic [NBANK-1:0] bank_open,
  input logic             cmd_bad
);
  logic [3:0] c;
  logic [BA_W-1:0] ba_d;
  assign c = {sel_n, row_n, col_n, wen_n};

  always_ff @(posedge clk) ba_d <= bank_sel;

  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0011 && !bank_open[bank_sel]) |=> bank_open[ba_d]);

  assert_act_twice_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0011 && bank_open[bank_sel]) |=> cmd_bad);

  assert_rw_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((c == 4'b0101 || c == 4'b0100) && !bank_open[bank_sel]) |=> cmd_bad);

  assert_pre_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0010 && ap) |=> (bank_open == '0 && !cmd_bad));

  assert_ref_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((c == 4'b0001 || c == 4'b0000) && bank_open != '0) |=> cmd_bad);

  assert_nop_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || c == 4'b0111) |=> !cmd_bad);

  assert_resv_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0110) |=> cmd_bad);
endmodule

bind ddr2_bank_guard ddr2_bank_guard_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .row_n(row_n), .col_n(col_n),
  .wen_n(wen_n), .bank_sel(bank_sel), .ap(addr[AP_BIT]),
  .bank_open(bank_open), .cmd_bad(cmd_bad)
);

// File: tb/tb_ddr2_bank_guard.sv
`timescale 1ns/1ps
module tb_ddr2_bank_guard;
  localparam logic [3:0] C_LM = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101,
                         C_RSV = 4'b0110, C_NOP = 4'b0111, C_DES = 4'b1000;
  localparam logic [13:0] AP = 14'h0400;

  logic clk = 0, rst_n = 0;
  logic sel_n = 1, row_n = 1, col_n = 1, wen_n = 1, bl8 = 0;
  logic [2:0] bank_sel = 0;
  logic [13:0] addr = 0;
  logic [7:0] bank_open;
  logic [13:0] cur_row;
  logic cmd_bad, all_idle;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ddr2_bank_guard dut (.clk, .rst_n, .sel_n, .row_n, .col_n, .wen_n,
    .bank_sel, .addr, .bl8, .bank_open, .cur_row, .cmd_bad, .all_idle);

  typedef struct { logic bad; logic [7:0] open; string tag; } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c, input logic [2:0] ba, input logic [13:0] a,
                       input logic b8, input logic xbad, input logic [7:0] xopen, input string tag);
    @(negedge clk);
    {sel_n, row_n, col_n, wen_n} = c;
    bank_sel = ba; addr = a; bl8 = b8;
    @(posedge clk);
    q.push_back('{xbad, xopen, tag});
  endtask

  task automatic row_is(input logic [2:0] ba, input logic [13:0] xrow, input string tag);
    @(negedge clk);
    {sel_n, row_n, col_n, wen_n} = C_NOP;
    bank_sel = ba;
    #1;
    chk(cur_row == xrow, tag, cur_row, xrow);
  endtask

  always @(negedge clk) begin : monitor
    exp_t e;
    if (q.size() != 0) begin
      e = q.pop_front();
      chk(cmd_bad == e.bad, {e.tag, " cmd_bad"}, cmd_bad, e.bad);
      chk(bank_open == e.open && all_idle == (e.open == 0), {e.tag, " bank_open"}, bank_open, e.open);
    end
  end

  initial begin : watchdog
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(bank_open == 0 && all_idle && !cmd_bad, "R1 reset state", bank_open, 0);

    issue(C_NOP, 0, 0, 0, 0, 8'h00, "R7 nop");
    issue(C_REF, 0, 0, 0, 0, 8'h00, "R6 refresh idle");
    issue(C_LM,  0, 0, 0, 0, 8'h00, "R6 load mode idle");
    issue(C_RD,  0, 0, 0, 1, 8'h00, "R3 read closed bank");
    issue(C_ACT, 0, 14'h1234, 0, 0, 8'h01, "R2 activate");
    issue(C_ACT, 0, 14'h0555, 0, 1, 8'h01, "R2 R9 activate open bank");
    row_is(0, 14'h1234, "R9 row kept");
    issue(C_ACT, 3, 14'h0abc, 0, 0, 8'h09, "R2 activate bank3");
    row_is(3, 14'h0abc, "R2 row bank3");
    issue(C_WR,  3, 0, 0, 0, 8'h09, "R3 write open");
    issue(C_REF, 0, 0, 0, 1, 8'h09, "R6 refresh busy");
    issue(C_RSV, 0, 0, 0, 1, 8'h09, "R8 reserved code");
    issue(C_DES, 0, 0, 0, 0, 8'h09, "R7 R8 deselect pulse end");
    issue(C_PRE, 0, 0, 0, 0, 8'h08, "R4 single precharge");
    issue(C_PRE, 5, AP, 0, 0, 8'h00, "R4 all precharge");
    issue(C_ACT, 1, 14'h0011, 0, 0, 8'h02, "R2 activate bank1");
    issue(C_RD,  1, 0, 0, 0, 8'h02, "R3 read bank1");
    issue(C_PRE, 1, 0, 0, 0, 8'h00, "R4 close bank1");
    issue(C_REF, 0, 0, 0, 1, 8'h00, "R6 refresh during burst");
    issue(C_REF, 0, 0, 0, 0, 8'h00, "R6 refresh after burst");
    issue(C_ACT, 2, 14'h0222, 0, 0, 8'h04, "R2 activate bank2");
    issue(C_RD,  2, AP, 0, 0, 8'h04, "R5 read auto close");
    issue(C_RD,  2, 0, 0, 1, 8'h04, "R5 read while closing");
    issue(C_ACT, 2, 14'h0333, 0, 1, 8'h00, "R10 activate on expiry edge");
    issue(C_ACT, 2, 14'h0333, 0, 0, 8'h04, "R10 activate after expiry");
    row_is(2, 14'h0333, "R2 new row bank2");
    issue(C_WR,  2, AP, 1, 0, 8'h04, "R5 write auto close bl8");
    issue(C_NOP, 0, 0, 0, 0, 8'h04, "R5 bl8 open 1");
    issue(C_NOP, 0, 0, 0, 0, 8'h04, "R5 bl8 open 2");
    issue(C_NOP, 0, 0, 0, 0, 8'h04, "R5 bl8 open 3");
    issue(C_ACT, 5, 14'h0055, 0, 0, 8'h20, "R10 expiry with other bank");
    issue(C_LM,  0, 0, 0, 1, 8'h20, "R6 load mode bank open");
    issue(C_PRE, 5, 0, 0, 0, 8'h00, "R4 close bank5");
    issue(C_LM,  0, 0, 0, 0, 8'h00, "R6 load mode quiet");
    repeat (3) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule